// File: doc/BRIEF.md
# Prioritized Nesting Interrupt Collector

The collector gathers 64 level-sensitive interrupt request lines into one CPU interrupt output. Software programs each source with an enable, a software-trigger bit and a two-bit priority. Every cycle the block works out the highest-priority pending source. It exposes that source's number in a status register and a vector address built from a programmable table base.

The collector records which priority levels are being serviced. A request at a strictly higher level can preempt the level in service, unless nesting is switched off. A handler enters service either by writing the vector register or, in a selectable mode, by reading it. The handler ends service by writing the level's bit to the acknowledge register.

All registers sit on a simple 32-bit read/write bus. Each register has four alias addresses: plain write, set bits, clear bits and toggle bits.

Top module: `icoll_top`

## Requirements
- R1: After synchronous reset, all stored registers, the in-service levels, `irq_out` and `bus_rdata` are zero.
- R2: A source is pending when its enable bit is 1 and either its request line or its software bit is 1. The selected source has the highest priority, where 3 is highest and 0 is lowest. Among sources at the same priority, the lowest source number wins. The status register at 0x030 shows the shown source number in bits 5:0 and reads zero above them.
- R3: Source n is configured in the register at 0x060 + 0x10*(n/4), in the byte at bit offset 8*(n%4). In that byte, bits 1:0 are the priority, bit 2 is the enable and bit 3 is the software request. All 32 bits of a configuration register are stored and read back.
- R4: The vector register at 0x000 reads the table base plus 4 times the shown source number. The table base register at 0x160 stores bits 31:2, and its bits 1:0 read zero.
- R5: The register index is address bits 8:4, and address bits 3:2 select the alias. Alias 0 writes the data. Alias 1 ORs the data in, alias 2 clears the bits that are set in the data, and alias 3 XORs the data in. Reads at any alias return the register. The control register at 0x020 keeps only bits 16, 18 and 19; its other bits read zero.
- R6: A request is eligible in two cases: when a source is pending and no level is in service, or, with nesting allowed, when the selected level is strictly greater than the highest level in service. `irq_out` is a register that equals control bit 16 AND eligibility, one clock late.
- R7: Entering service happens only while a request is eligible and control bit 16 is 1. It marks the selected level in service and latches the selected source for that level. With control bit 18 at 0, a write at any vector alias triggers it and a read does not. With control bit 18 at 1, a read triggers it and a write does not. In every other case the access is ignored.
- R8: When no request is eligible and some level is in service, status and vector show the source latched for the highest level in service. Otherwise they show the selected source.
- R9: A write at any alias of the acknowledge register at 0x010 removes service from each level k whose data bit k is 1. Reading that register returns the in-service level bits in bits 3:0.
- R10: With control bit 19 at 1 (no nesting), no request is eligible while any level is in service.
- R11: Registers 0x040 and 0x050 read request lines 31:0 and 63:32 respectively, and writes to them have no effect.
- R12: Reads of unmapped register indices return zero. The scratch register at 0x1F0 reads back the value last stored in it.
- R13: `bus_rdata` carries the read value in the cycle after `bus_rd` is high, and is zero otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 9 | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| irq_lines | input | 64 | Level-sensitive request lines |
| irq_out | output | 1 | Registered CPU interrupt request |

## Verification
Some properties are checked on every cycle:
- the selected source is actually pending;
- entering service adds at most one level per cycle;
- no level is added while nesting is off and a level is already in service;
- `irq_out` is never high unless the global enable was set;
- read data is zero when no read was issued.

Other behaviour shows only in the bench's scenarios, against its behavioural model: the tie-break by source number, preemption and return to the latched source after an acknowledge, and the choice of read or write as the service trigger. The same holds for alias arithmetic, ignored writes to the raw registers and the vector arithmetic.

// File: rtl/icoll_pkg.sv
package icoll_pkg;
  localparam int N_LVL  = 4;
  localparam int LVL_W  = 2;
  localparam int SLOT_W = 5;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLR   = 2'd2,
    OP_TOG   = 2'd3
  } alias_op_t;

  localparam logic [SLOT_W-1:0] SLOT_VEC  = 5'd0;
  localparam logic [SLOT_W-1:0] SLOT_ACK  = 5'd1;
  localparam logic [SLOT_W-1:0] SLOT_CTRL = 5'd2;
  localparam logic [SLOT_W-1:0] SLOT_STAT = 5'd3;
  localparam logic [SLOT_W-1:0] SLOT_RAW0 = 5'd4;
  localparam logic [SLOT_W-1:0] SLOT_RAW1 = 5'd5;
  localparam int                SLOT_CFG0 = 6;
  localparam logic [SLOT_W-1:0] SLOT_SCR  = 5'd31;

  localparam int CTRL_EN_BIT    = 16;
  localparam int CTRL_RSE_BIT   = 18;
  localparam int CTRL_NONEST_BIT = 19;

  function automatic logic [31:0] apply_op(alias_op_t op, logic [31:0] old_v,
                                           logic [31:0] wd);
    case (op)
      OP_WRITE: apply_op = wd;
      OP_SET:   apply_op = old_v | wd;
      OP_CLR:   apply_op = old_v & ~wd;
      default:  apply_op = old_v ^ wd;
    endcase
  endfunction
endpackage

// File: rtl/icoll_arbiter.sv
module icoll_arbiter
  import icoll_pkg::*;
#(
  parameter int N_SRC = 64,
  parameter int IDX_W = $clog2(N_SRC)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [N_SRC-1:0]       src_en,
  input  logic [N_SRC-1:0]       src_soft,
  input  logic [N_SRC-1:0]       src_raw,
  input  logic [N_SRC*LVL_W-1:0] src_prio,
  output logic                   any_pend,
  output logic [IDX_W-1:0]       win_idx,
  output logic [LVL_W-1:0]       win_lvl
);
  logic [N_SRC-1:0] pending;
  assign pending = src_en & (src_raw | src_soft);

  // Scan from the top index down; ">=" lets a lower index take a tie.
  always_comb begin
    any_pend = 1'b0;
    win_idx  = '0;
    win_lvl  = '0;
    for (int n = N_SRC - 1; n >= 0; n--) begin
      if (pending[n] && (!any_pend || src_prio[n*LVL_W +: LVL_W] >= win_lvl)) begin
        any_pend = 1'b1;
        win_idx  = IDX_W'(n);
        win_lvl  = src_prio[n*LVL_W +: LVL_W];
      end
    end
  end

  assert_win_pending_R2: assert property (@(posedge clk) disable iff (rst)
    any_pend |-> pending[win_idx]);
endmodule

// File: rtl/icoll_service.sv
module icoll_service
  import icoll_pkg::*;
#(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             any_pend,
  input  logic [IDX_W-1:0] win_idx,
  input  logic [LVL_W-1:0] win_lvl,
  input  logic             no_nest,
  input  logic             take,
  input  logic [N_LVL-1:0] ack,
  output logic             want,
  output logic [N_LVL-1:0] insvc,
  output logic [IDX_W-1:0] shown_idx
);
  logic [N_LVL-1:0] insvc_q;
  logic [IDX_W-1:0] lat_q [N_LVL];
  logic [LVL_W-1:0] top_lvl;
  logic             busy;
  logic             take_ok;

  always_comb begin
    top_lvl = '0;
    for (int k = 0; k < N_LVL; k++)
      if (insvc_q[k]) top_lvl = LVL_W'(k);
  end

  assign busy      = |insvc_q;
  assign want      = any_pend && (!busy || (!no_nest && win_lvl > top_lvl));
  assign take_ok   = take && want;
  assign shown_idx = (want || !busy) ? win_idx : lat_q[top_lvl];
  assign insvc     = insvc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      insvc_q <= '0;
      for (int k = 0; k < N_LVL; k++) lat_q[k] <= '0;
    end else begin
      insvc_q <= (insvc_q & ~ack) | (take_ok ? (N_LVL'(1) << win_lvl) : '0);
      if (take_ok) lat_q[win_lvl] <= win_idx;
    end
  end

  assert_one_new_level_R7: assert property (@(posedge clk) disable iff (rst)
    $countones(insvc_q & ~$past(insvc_q)) <= 1);

  assert_no_nest_hold_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(no_nest) && ($past(insvc_q) != '0)) |-> ((insvc_q & ~$past(insvc_q)) == '0));
endmodule

// File: rtl/icoll_top.sv
module icoll_top
  import icoll_pkg::*;
#(
  parameter int N_SRC  = 64,
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic [N_SRC-1:0]  irq_lines,
  output logic              irq_out
);
  localparam int IDX_W    = $clog2(N_SRC);
  localparam int CFG_REGS = N_SRC / 4;
  localparam logic [SLOT_W-1:0] SLOT_VBASE = SLOT_W'(SLOT_CFG0 + CFG_REGS);

  logic [SLOT_W-1:0] slot;
  alias_op_t         op;
  logic [1:0]        unused_addr_lsb;
  assign slot            = bus_addr[8:4];
  assign op              = alias_op_t'(bus_addr[3:2]);
  assign unused_addr_lsb = bus_addr[1:0];

  logic [31:0] cfg_q [CFG_REGS];
  logic        en_q, rse_q, nonest_q;
  logic [31:0] vbase_q, scratch_q;
  logic [31:0] ctrl_word, ctrl_new;

  assign ctrl_word = (32'(en_q) << CTRL_EN_BIT) | (32'(rse_q) << CTRL_RSE_BIT) |
                     (32'(nonest_q) << CTRL_NONEST_BIT);
  assign ctrl_new  = apply_op(op, ctrl_word, bus_wdata);

  logic [N_SRC-1:0]       src_en, src_soft;
  logic [N_SRC*LVL_W-1:0] src_prio;

  for (genvar g = 0; g < N_SRC; g++) begin : g_lane
    assign src_prio[g*LVL_W +: LVL_W] = cfg_q[g/4][8*(g%4) +: 2];
    assign src_en[g]                  = cfg_q[g/4][8*(g%4) + 2];
    assign src_soft[g]                = cfg_q[g/4][8*(g%4) + 3];
  end

  for (genvar g = 0; g < CFG_REGS; g++) begin : g_cfg
    localparam logic [SLOT_W-1:0] MY_SLOT = SLOT_W'(SLOT_CFG0 + g);
    always_ff @(posedge clk) begin
      if (rst) cfg_q[g] <= '0;
      else if (bus_wr && slot == MY_SLOT) cfg_q[g] <= apply_op(op, cfg_q[g], bus_wdata);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= 1'b0;
      rse_q     <= 1'b0;
      nonest_q  <= 1'b0;
      vbase_q   <= '0;
      scratch_q <= '0;
    end else if (bus_wr) begin
      if (slot == SLOT_CTRL) begin
        en_q     <= ctrl_new[CTRL_EN_BIT];
        rse_q    <= ctrl_new[CTRL_RSE_BIT];
        nonest_q <= ctrl_new[CTRL_NONEST_BIT];
      end
      if (slot == SLOT_VBASE) vbase_q   <= apply_op(op, vbase_q, bus_wdata) & 32'hFFFF_FFFC;
      if (slot == SLOT_SCR)   scratch_q <= apply_op(op, scratch_q, bus_wdata);
    end
  end

  logic             any_pend, want, take;
  logic [IDX_W-1:0] win_idx, shown_idx;
  logic [LVL_W-1:0] win_lvl;
  logic [N_LVL-1:0] insvc, ack;

  icoll_arbiter #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_arb (
    .clk(clk), .rst(rst), .src_en(src_en), .src_soft(src_soft),
    .src_raw(irq_lines), .src_prio(src_prio), .any_pend(any_pend),
    .win_idx(win_idx), .win_lvl(win_lvl)
  );

  assign take = en_q && (slot == SLOT_VEC) && (rse_q ? bus_rd : bus_wr);
  assign ack  = (bus_wr && slot == SLOT_ACK) ? bus_wdata[N_LVL-1:0] : '0;

  icoll_service #(.IDX_W(IDX_W)) u_svc (
    .clk(clk), .rst(rst), .any_pend(any_pend), .win_idx(win_idx),
    .win_lvl(win_lvl), .no_nest(nonest_q), .take(take), .ack(ack),
    .want(want), .insvc(insvc), .shown_idx(shown_idx)
  );

  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    case (slot)
      SLOT_VEC:   rd_val = vbase_q + {{(32-IDX_W-2){1'b0}}, shown_idx, 2'b00};
      SLOT_ACK:   rd_val = {{(32-N_LVL){1'b0}}, insvc};
      SLOT_CTRL:  rd_val = ctrl_word;
      SLOT_STAT:  rd_val = {{(32-IDX_W){1'b0}}, shown_idx};
      SLOT_RAW0:  rd_val = irq_lines[31:0];
      SLOT_RAW1:  rd_val = irq_lines[63:32];
      SLOT_VBASE: rd_val = vbase_q;
      SLOT_SCR:   rd_val = scratch_q;
      default: begin
        for (int g = 0; g < CFG_REGS; g++)
          if (slot == SLOT_W'(SLOT_CFG0 + g)) rd_val = cfg_q[g];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      bus_rdata <= bus_rd ? rd_val : '0;
      irq_out   <= en_q && want;
    end
  end

  assert_irq_gated_R6: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> $past(en_q));

  assert_rdata_idle_R13: assert property (@(posedge clk) disable iff (rst)
    !$past(bus_rd) |-> (bus_rdata == '0));
endmodule

// File: tb/tb_icoll_top.sv
module tb_icoll_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [8:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [63:0] irq_lines = '0;
  logic        irq_out;

  icoll_top dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .irq_lines(irq_lines), .irq_out(irq_out)
  );

  always #5 clk = ~clk;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    done = 0;
  string cur_req = "R1";

  // Behavioural reference model
  logic [31:0] m_cfg [16];
  logic [31:0] m_ctrl, m_vbase, m_scr, m_rdata;
  bit          m_irq;
  bit   [3:0]  m_insvc;
  int          m_lat [4];

  function automatic void m_select(output bit any, output int lvl, output int idx);
    any = 0; lvl = 0; idx = 0;
    for (int n = 0; n < 64; n++) begin
      logic [7:0] lane;
      lane = m_cfg[n/4][8*(n%4) +: 8];
      if (lane[2] && (irq_lines[n] || lane[3]) && (!any || int'(lane[1:0]) > lvl)) begin
        any = 1; lvl = int'(lane[1:0]); idx = n;
      end
    end
  endfunction

  function automatic int m_top();
    m_top = -1;
    for (int k = 0; k < 4; k++) if (m_insvc[k]) m_top = k;
  endfunction

  function automatic bit m_eligible();
    bit any; int lvl, idx, t;
    m_select(any, lvl, idx);
    t = m_top();
    if (!any) return 0;
    if (t < 0) return 1;
    return !m_ctrl[19] && lvl > t;
  endfunction

  function automatic int m_shown();
    bit any; int lvl, idx;
    m_select(any, lvl, idx);
    if (m_eligible() || m_top() < 0) return idx;
    return m_lat[m_top()];
  endfunction

  function automatic logic [31:0] m_read(logic [8:0] a);
    int s;
    s = int'(a[8:4]);
    if (s == 0) return m_vbase + 32'(4 * m_shown());
    if (s == 1) return {28'b0, m_insvc};
    if (s == 2) return m_ctrl;
    if (s == 3) return 32'(m_shown());
    if (s == 4) return irq_lines[31:0];
    if (s == 5) return irq_lines[63:32];
    if (s >= 6 && s < 22) return m_cfg[s-6];
    if (s == 22) return m_vbase;
    if (s == 31) return m_scr;
    return 32'h0;
  endfunction

  function automatic logic [31:0] m_op(logic [1:0] o, logic [31:0] v, logic [31:0] d);
    if (o == 2'd0) return d;
    if (o == 2'd1) return v | d;
    if (o == 2'd2) return v & ~d;
    return v ^ d;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 16; k++) m_cfg[k] = '0;
      m_ctrl = '0; m_vbase = '0; m_scr = '0; m_rdata = '0; m_irq = 0;
      m_insvc = '0;
      for (int k = 0; k < 4; k++) m_lat[k] = 0;
    end else begin
      logic [31:0] nxt_rd;
      bit nxt_irq, elig, any, do_take;
      int lvl, idx, s;
      logic [1:0] o;
      s = int'(bus_addr[8:4]);
      o = bus_addr[3:2];
      nxt_rd  = bus_rd ? m_read(bus_addr) : 32'h0;
      elig    = m_eligible();
      nxt_irq = m_ctrl[16] && elig;
      m_select(any, lvl, idx);
      do_take = m_ctrl[16] && elig && s == 0 && (m_ctrl[18] ? bus_rd : bus_wr);
      if (bus_wr && s == 1) m_insvc = m_insvc & ~bus_wdata[3:0];
      if (do_take) begin
        m_insvc[lvl] = 1'b1;
        m_lat[lvl]   = idx;
      end
      if (bus_wr) begin
        if (s == 2) m_ctrl = m_op(o, m_ctrl, bus_wdata) & 32'h000D_0000;
        if (s >= 6 && s < 22) m_cfg[s-6] = m_op(o, m_cfg[s-6], bus_wdata);
        if (s == 22) m_vbase = m_op(o, m_vbase, bus_wdata) & 32'hFFFF_FFFC;
        if (s == 31) m_scr = m_op(o, m_scr, bus_wdata);
      end
      m_rdata = nxt_rd;
      m_irq   = nxt_irq;
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    cyc++;
    if (!rst && !done) begin
      n_cmp++;
      if (bus_rdata !== m_rdata) begin
        n_bad++;
        $display("FAIL %s: bus_rdata actual %h expected %h (cycle %0d)", cur_req, bus_rdata, m_rdata, cyc);
      end
      n_cmp++;
      if (irq_out !== m_irq) begin
        n_bad++;
        $display("FAIL %s: irq_out actual %0b expected %0b (cycle %0d)", cur_req, irq_out, m_irq, cyc);
      end
    end
    if (cyc > 20000 && !done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wr(input logic [8:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [8:0] a);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset values
    cur_req = "R1";
    rd(9'h030); rd(9'h020); rd(9'h060); rd(9'h160); rd(9'h000); idle(2);
    // R3 / R5: lane storage and alias arithmetic
    cur_req = "R5";
    wr(9'h080, 32'h1234_5678); rd(9'h080);
    wr(9'h084, 32'h0000_0F00); rd(9'h08C);
    wr(9'h088, 32'h0000_00F0); rd(9'h080);
    wr(9'h08C, 32'hFFFF_0000); rd(9'h084);
    cur_req = "R3";
    wr(9'h080, 32'h0); rd(9'h080);
    wr(9'h020, 32'hFFFF_FFFF); rd(9'h020); wr(9'h020, 32'h0); rd(9'h020);
    // R12: scratch and unmapped
    cur_req = "R12";
    wr(9'h1F0, 32'hDEAD_BEEF); rd(9'h1F0);
    wr(9'h1F4, 32'h0000_0011); rd(9'h1F0);
    rd(9'h170); rd(9'h1E0);
    // R11: raw view, writes ignored
    cur_req = "R11";
    irq_lines = 64'hA5A5_0000_0000_0F0F;
    idle(1); rd(9'h040); rd(9'h050);
    wr(9'h040, 32'hFFFF_FFFF); rd(9'h040);
    irq_lines = '0; idle(1); rd(9'h050);
    // R2: selection
    cur_req = "R2";
    wr(9'h070, 32'h0000_0500);   // source 5: en, prio 1
    wr(9'h080, 32'h0000_0E00);   // source 9: en, soft, prio 2
    wr(9'h100, 32'h0000_0006);   // source 40: en, prio 2
    wr(9'h150, 32'h0300_0000);   // source 63: prio 3, disabled
    irq_lines[5] = 1'b1; irq_lines[40] = 1'b1; irq_lines[63] = 1'b1;
    idle(1); rd(9'h030);
    wr(9'h088, 32'h0000_0800); rd(9'h030);
    irq_lines[40] = 1'b0; idle(1); rd(9'h030);
    wr(9'h154, 32'h0400_0000); rd(9'h030);
    // R4: vector arithmetic
    cur_req = "R4";
    wr(9'h160, 32'h8000_1003); rd(9'h160); rd(9'h000);
    // R6: global enable
    cur_req = "R6";
    idle(3);
    wr(9'h024, 32'h0001_0000); idle(3);
    // R7: normal mode write trigger
    cur_req = "R7";
    rd(9'h000); rd(9'h010);
    wr(9'h000, 32'h0); rd(9'h010);
    cur_req = "R8";
    rd(9'h030); idle(2);
    cur_req = "R9";
    wr(9'h010, 32'h8); rd(9'h010); idle(2);
    // R8: nesting and return to latched source
    cur_req = "R8";
    irq_lines[63] = 1'b0; idle(1);
    wr(9'h000, 32'h0); rd(9'h010);
    irq_lines[40] = 1'b1; idle(2); rd(9'h030);
    wr(9'h000, 32'h0); rd(9'h010); rd(9'h030);
    irq_lines[40] = 1'b0; idle(1); rd(9'h030);
    wr(9'h014, 32'h4); rd(9'h030); rd(9'h000); rd(9'h010);
    // R10: no nesting
    cur_req = "R10";
    wr(9'h024, 32'h0008_0000);
    irq_lines[40] = 1'b1; idle(3); rd(9'h030);
    wr(9'h000, 32'h0); rd(9'h010);
    wr(9'h010, 32'h2); idle(2); rd(9'h030);
    wr(9'h000, 32'h0); rd(9'h010);
    irq_lines[63] = 1'b1; idle(3); rd(9'h030);
    wr(9'h010, 32'h4); idle(2);
    // R7: read side effect mode
    cur_req = "R7";
    wr(9'h024, 32'h0004_0000); idle(1);
    wr(9'h000, 32'h0); rd(9'h010);
    rd(9'h000); rd(9'h010); idle(2);
    wr(9'h010, 32'hF); idle(2);
    wr(9'h028, 32'h0001_0000); rd(9'h000); rd(9'h010); idle(2);
    // R13: idle read data
    cur_req = "R13";
    idle(4);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule